// File: doc/BRIEF.md
# Video Frame Timing Generator

This block counts pixel clocks into a dot index along each scanline and a line index down the frame for a tile-based video processor. Whenever reset is released it starts again at the top of the visible picture, at line 0 and dot 0. A mode input chooses between a 60 Hz frame of 262 lines and a 50 Hz frame of 312 lines. Every line is 341 pixel clocks long in both modes.

From the counter it derives two timing outputs. The first is a one-cycle pulse that marks the start of vertical blanking. The CPU-side logic uses it to set its blanking flag. The second is an unlock level. It tells the register interface that writes it had to hold off after reset are now legal. The unlock level rises a fixed number of pixel clocks before a given scanline begins. That scanline is 261 in 60 Hz mode and 311 in 50 Hz mode. The offset is 27 pixel clocks in 60 Hz mode and 29 in 50 Hz mode, which is about nine CPU clocks at each mode's clock ratio. Once high, the unlock level stays high until the next reset.

Top module: `frame_timer`

## Requirements
- R1: While reset is asserted, `dot` and `line` read 0, `vblank_set` reads 0 and `unlock` reads 0.
- R2: `dot` advances by one on each clock from 0 up to 340. After 340 it returns to 0 and `line` advances by one.
- R3: In 60 Hz mode (`mode_50hz` = 0) the frame has lines 0 to 261. After line 261 dot 340, the outputs read line 0 dot 0.
- R4: In 50 Hz mode (`mode_50hz` = 1) the frame has lines 0 to 311. After line 311 dot 340, the outputs read line 0 dot 0.
- R5: `vblank_set` is high for exactly the one cycle in which the outputs read line 241 dot 1. This holds in both modes, and it is low in every other cycle.
- R6: In 60 Hz mode `unlock` first reads 1 in the cycle that shows line 260 dot 314. That is 27 pixel clocks before line 261 starts, and it is 0 in the cycle before.
- R7: In 50 Hz mode `unlock` first reads 1 in the cycle that shows line 310 dot 312. That is 29 pixel clocks before line 311 starts, and it is 0 in the cycle before.
- R8: Once high, `unlock` stays high through the line wrap until reset. Reset returns it to 0.
- R9: A reset asserted in the middle of a frame returns the counter to line 0 dot 0. After release, counting starts again from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_50hz | input | 1 | 0 selects the 262-line frame, 1 selects the 312-line frame |
| dot | output | 9 | Dot index within the current line |
| line | output | 9 | Line index within the current frame |
| vblank_set | output | 1 | One-cycle pulse at line 241 dot 1 |
| unlock | output | 1 | Sticky level marking the end of the post-reset write lockout |

## Verification
The counter is run from reset through a complete 60 Hz frame and a complete 50 Hz frame. Expected values are sampled on both sides of each event: the line boundary, the blanking pulse, the unlock edge and the frame wrap. Checking the cycle before and the cycle after each event catches an off-by-one in either direction. Running both modes shows that the line count and the unlock offset follow the mode input, while the blanking line does not. A reset in the middle of a frame and a reset after unlock check that the restart returns to the top of the picture and clears the sticky level.

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int DOTS           = 341,
  parameter int LINES_60       = 262,
  parameter int LINES_50       = 312,
  parameter int VBL_LINE       = 241,
  parameter int VBL_DOT        = 1,
  parameter int UNLOCK_LINE_60 = 261,
  parameter int UNLOCK_LINE_50 = 311,
  parameter int EARLY_60       = 27,
  parameter int EARLY_50       = 29
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_50hz,
  output logic [8:0] dot,
  output logic [8:0] line,
  output logic       vblank_set,
  output logic       unlock
);
  localparam int MAXL = (LINES_50 > LINES_60) ? LINES_50 : LINES_60;
  localparam int DW   = $clog2(DOTS);
  localparam int LW   = $clog2(MAXL);
  localparam int U60L = UNLOCK_LINE_60 - 1;
  localparam int U60D = DOTS - EARLY_60;
  localparam int U50L = UNLOCK_LINE_50 - 1;
  localparam int U50D = DOTS - EARLY_50;

  logic [DW-1:0] dot_q;
  logic [LW-1:0] line_q;
  logic          unlock_q;

  wire          last_dot  = dot_q == DW'(DOTS - 1);
  wire [LW-1:0] last_line = mode_50hz ? LW'(LINES_50 - 1) : LW'(LINES_60 - 1);
  wire          at_unlock = mode_50hz ? (line_q == LW'(U50L) && dot_q == DW'(U50D))
                                      : (line_q == LW'(U60L) && dot_q == DW'(U60D));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q    <= '0;
      line_q   <= '0;
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= unlock;
      if (last_dot) begin
        dot_q  <= '0;
        line_q <= (line_q >= last_line) ? '0 : line_q + 1'b1;
      end else begin
        dot_q <= dot_q + 1'b1;
      end
    end
  end

  assign dot        = 9'(dot_q);
  assign line       = 9'(line_q);
  assign vblank_set = (line_q == LW'(VBL_LINE)) && (dot_q == DW'(VBL_DOT));
  assign unlock     = unlock_q | at_unlock;

  assert_dot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != 9'(DOTS - 1)) |=> (dot == $past(dot) + 9'd1 && line == $past(line)));
  assert_dot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == 9'(DOTS - 1)) |=> (dot == 9'd0));
  assert_frame_wrap_60_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_50hz && line == 9'(LINES_60 - 1) && dot == 9'(DOTS - 1)) |=> (line == 9'd0));
  assert_frame_wrap_50_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_50hz && line == 9'(LINES_50 - 1) && dot == 9'(DOTS - 1)) |=> (line == 9'd0));
  assert_vblank_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_set |=> !vblank_set);
  assert_unlock_edge_60_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_50hz && $rose(unlock)) |-> (line == 9'(U60L) && dot == 9'(U60D)));
  assert_unlock_edge_50_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_50hz && $rose(unlock)) |-> (line == 9'(U50L) && dot == 9'(U50D)));
  assert_unlock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> unlock);
endmodule

// File: tb/frame_timer_bench.sv
module frame_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_50hz = 1'b0;
  logic [8:0] dot, line;
  logic       vblank_set, unlock;

  int applied = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    k;
    string tag;
  } item_t;
  item_t q[$];
  item_t it;

  always #5 clk = ~clk;

  frame_timer u_frame_timer (
    .clk(clk), .rst_n(rst_n), .mode_50hz(mode_50hz),
    .dot(dot), .line(line), .vblank_set(vblank_set), .unlock(unlock)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic push(input int k, input string tag);
    item_t n;
    n.k = k;
    n.tag = tag;
    q.push_back(n);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].k == cyc) begin
      int frame, ed, el, tgt;
      bit ev, eu;
      it = q.pop_front();
      frame = mode_50hz ? 312 : 262;
      tgt   = mode_50hz ? (310 * 341 + 312) : (260 * 341 + 314);
      ed = it.k % 341;
      el = (it.k / 341) % frame;
      ev = (el == 241) && (ed == 1) && rst_n;
      eu = rst_n && (it.k >= tgt);
      applied++;
      if (dot !== 9'(ed) || line !== 9'(el) || vblank_set !== ev || unlock !== eu) begin
        miscompares++;
        $display("FAIL %s k=%0d actual line=%0d dot=%0d vb=%b un=%b expected line=%0d dot=%0d vb=%b un=%b",
                 it.tag, it.k, line, dot, vblank_set, unlock, el, ed, ev, eu);
      end
    end
  end

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic hold_reset(input bit m, input string tag);
    rst_n = 1'b0;
    mode_50hz = m;
    push(0, tag);
    drain();
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    @(posedge clk); #1;
    hold_reset(1'b0, "R1");
    push(1000, "R2");
    drain();
    hold_reset(1'b0, "R9");
    push(340, "R2");    push(341, "R2");
    push(82181, "R5");  push(82182, "R5");  push(82183, "R5");
    push(88973, "R6");  push(88974, "R6");  push(88975, "R6");
    push(89341, "R3");  push(89342, "R3_R8"); push(89343, "R3");
    drain();
    hold_reset(1'b1, "R8");
    push(82181, "R5");  push(82182, "R5");  push(82183, "R5");
    push(106021, "R7"); push(106022, "R7"); push(106023, "R7");
    push(106051, "R4"); push(106391, "R4"); push(106392, "R4_R8");
    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired with %0d items pending", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule